// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block sits between a synchronous on-chip requester and an external byte-wide static RAM that has no clock. It takes one single-word read or write at a time from a valid/ready request port. It then drives the RAM's address, chip select, write strobe and output enable in the order the RAM needs. Each phase lasts a whole number of controller clock cycles, set by parameters and rounded up from the RAM's nanosecond limits.

A read holds chip select and output enable low with the write strobe high. It samples the data bus on the last edge of the access window, before the address can move, and reports the byte with a one-cycle done pulse. A write first sets up the address and chip select. It then starts driving the data bus, pulses the write strobe low, and raises the write strobe and chip select together. The controller keeps output enable high for the whole write. It turns on its own bus driver only after output enable has been high long enough for the RAM to release the bus. It turns the driver off on the same edge that ends the write, which is allowed because the data hold time is zero.

The data bus appears as separate in, out and drive-enable signals, and the pad that joins them sits outside the block. Every cycle ends with a recovery interval, and a new request is accepted only from the idle state.

Top module: `async_sram_ctrl`

## Requirements
- R1: While reset is asserted and right after it, chip select, write strobe and output enable are all high (inactive), the drive enable is low, req_ready is high and rd_done is low.
- R2: A read holds chip select and output enable low and the write strobe high for exactly T_RD cycles. rd_data is the bus value on the edge that ends this window. rd_done is high for exactly one cycle, starting on that same edge, and chip select and output enable rise on that edge too.
- R3: Output enable is high in every cycle where the write strobe is low or the drive enable is high.
- R4: The drive enable rises only after output enable has been high for at least T_TURN cycles, so it never overlaps the RAM's own drive window, including the RAM's release time after output enable rises.
- R5: A write holds the write strobe low for exactly T_WP cycles. Chip select is low for at least T_WSETUP cycles before the strobe falls. Address and data stay stable and the drive enable stays high during the whole strobe, and the drive enable falls on the edge where the strobe rises.
- R6: The write strobe is low only while chip select is low, and both rise on the same edge.
- R7: req_ready is high only in the idle state, with all strobes inactive. With req_valid low the strobes do not move.
- R8: The RAM address changes only while chip select is high.
- R9: With back-to-back requests, the cycle after a read starts T_RD+T_REC+1 cycles after the read was accepted. The cycle after a write starts W+T_WP+T_REC+1 cycles after it, where W is max(T_WSETUP, T_TURN-T_REC) if the write directly followed a read and T_WSETUP otherwise.
- R10: rd_done is never raised for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write byte |
| rd_done | output | 1 | One-cycle pulse when read data is valid |
| rd_data | output | DATA_W | Captured read byte |
| mem_addr | output | ADDR_W | RAM address |
| mem_cs_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | DATA_W | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | DATA_W | Data from the RAM bus |

## Verification
The bench builds the block with a 6-bit address, so every location can be written and then read back twice. The timing values are T_RD=4, T_WSETUP=1, T_WP=3, T_TURN=3 and T_REC=1. A turnaround of 3 exceeds what the recovery interval alone provides after a read. That makes the wait for the drive enable visible as a one-cycle stretch of a write that directly follows a read. The RAM model returns corrupted data until the full access time has passed. It also keeps driving for two cycles after output enable rises, so an early sample or an early drive enable shows up at the ports.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RACC,
        PH_WSET,
        PH_WPUL,
        PH_RECV
    } phase_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_turn_guard.sv
module sramc_turn_guard #(
    parameter int unsigned T_TURN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    output logic turn_ok_nxt
);
    localparam int unsigned QW = $clog2(T_TURN + 2);

    logic [QW-1:0] quiet_d, quiet_q;

    always_comb begin
        if (!oe_n)
            quiet_d = '0;
        else if (quiet_q == QW'(T_TURN))
            quiet_d = quiet_q;
        else
            quiet_d = quiet_q + 1'b1;
        turn_ok_nxt = (quiet_d >= QW'(T_TURN));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) quiet_q <= QW'(T_TURN);
        else        quiet_q <= quiet_d;
    end

endmodule

// File: rtl/sramc_rd_capture.sv
module sramc_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              done;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d      = cap_q;
        cap_d.done = cap_en;
        if (cap_en) cap_d.data = din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign rd_data = cap_q.data;
    assign rd_done = cap_q.done;

    a_r2_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl #(
    parameter int unsigned ADDR_W   = 19,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned T_RD     = 6,
    parameter int unsigned T_WSETUP = 1,
    parameter int unsigned T_WP     = 4,
    parameter int unsigned T_TURN   = 2,
    parameter int unsigned T_REC    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    import sramc_pkg::*;

    // all phase counts must be at least one cycle
    localparam int unsigned CNT_MAX = max2(max2(T_RD, T_WP), max2(T_WSETUP, T_REC));
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

    typedef struct packed {
        phase_e            ph;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdat;
        logic              cs_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
    } ctl_t;

    localparam ctl_t CTL_RST = '{ph: PH_IDLE, cnt: '0, addr: '0, wdat: '0,
                                 cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    ctl_t ctl_d, ctl_q;
    logic cap_en;
    logic turn_ok_nxt;

    sramc_turn_guard #(.T_TURN(T_TURN)) i_turn (
        .clk         (clk),
        .rst_n       (rst_n),
        .oe_n        (ctl_q.oe_n),
        .turn_ok_nxt (turn_ok_nxt)
    );

    always_comb begin
        ctl_d  = ctl_q;
        cap_en = 1'b0;
        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr = req_addr;
                    ctl_d.cs_n = 1'b0;
                    if (req_write) begin
                        ctl_d.ph   = PH_WSET;
                        ctl_d.cnt  = CNT_W'(T_WSETUP - 1);
                        ctl_d.wdat = req_wdata;
                    end else begin
                        ctl_d.ph   = PH_RACC;
                        ctl_d.cnt  = CNT_W'(T_RD - 1);
                        ctl_d.oe_n = 1'b0;
                    end
                end
            end
            PH_RACC: begin
                if (ctl_q.cnt == '0) begin
                    cap_en     = 1'b1;
                    ctl_d.cs_n = 1'b1;
                    ctl_d.oe_n = 1'b1;
                    ctl_d.ph   = PH_RECV;
                    ctl_d.cnt  = CNT_W'(T_REC - 1);
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            PH_WSET: begin
                if (ctl_q.cnt != '0) begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end else if (ctl_q.dq_oe) begin
                    ctl_d.we_n = 1'b0;
                    ctl_d.ph   = PH_WPUL;
                    ctl_d.cnt  = CNT_W'(T_WP - 1);
                end
            end
            PH_WPUL: begin
                if (ctl_q.cnt == '0) begin
                    ctl_d.we_n = 1'b1;
                    ctl_d.cs_n = 1'b1;
                    ctl_d.ph   = PH_RECV;
                    ctl_d.cnt  = CNT_W'(T_REC - 1);
                end else begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end
            end
            PH_RECV: begin
                if (ctl_q.cnt == '0) ctl_d.ph  = PH_IDLE;
                else                 ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
            default: ctl_d = CTL_RST;
        endcase
        ctl_d.dq_oe = ((ctl_d.ph == PH_WSET) || (ctl_d.ph == PH_WPUL)) && turn_ok_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= CTL_RST;
        else        ctl_q <= ctl_d;
    end

    sramc_rd_capture #(.DATA_W(DATA_W)) i_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .din     (mem_dq_in),
        .rd_data (rd_data),
        .rd_done (rd_done)
    );

    assign req_ready  = (ctl_q.ph == PH_IDLE);
    assign mem_addr   = ctl_q.addr;
    assign mem_cs_n   = ctl_q.cs_n;
    assign mem_we_n   = ctl_q.we_n;
    assign mem_oe_n   = ctl_q.oe_n;
    assign mem_dq_out = ctl_q.wdat;
    assign mem_dq_oe  = ctl_q.dq_oe;

    // ---- assertion support: window counters watched at the RAM pins ----
    localparam int unsigned KOW = $clog2(T_TURN + 2);
    localparam int unsigned KWW = $clog2(T_WP + 2);
    logic [KOW-1:0] ck_oe_hi;
    logic [KWW-1:0] ck_we_lo;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_oe_hi <= KOW'(T_TURN);
            ck_we_lo <= '0;
        end else begin
            if (!mem_oe_n)                     ck_oe_hi <= '0;
            else if (ck_oe_hi != KOW'(T_TURN)) ck_oe_hi <= ck_oe_hi + 1'b1;
            if (mem_we_n)                      ck_we_lo <= '0;
            else if (ck_we_lo != KWW'(T_WP))   ck_we_lo <= ck_we_lo + 1'b1;
        end
    end

    a_r1_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    a_r2_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_cs_n && mem_we_n));

    a_r3_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || mem_dq_oe) |-> mem_oe_n);

    a_r4_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (ck_oe_hi >= KOW'(T_TURN)));

    a_r5_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (ck_we_lo >= KWW'(T_WP)));

    a_r5_drive_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_dq_oe) |-> $rose(mem_we_n));

    a_r6_we_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_cs_n);

    a_r6_joint_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> $rose(mem_cs_n));

    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

// File: tb/test_async_sram_ctrl.sv
module test_async_sram_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6, DW = 8;
    localparam int TRD = 4, TWS = 1, TWP = 3, TTURN = 3, TREC = 1;
    localparam int RAM_REL = 2;
    localparam int NWORDS = 1 << AW;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic rd_done;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] mem_addr;
    logic mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out, mem_dq_in;

    async_sram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .T_RD(TRD), .T_WSETUP(TWS),
                      .T_WP(TWP), .T_TURN(TTURN), .T_REC(TREC)) i_async_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_done(rd_done), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_err = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural RAM ----------------
    logic [DW-1:0] ram [NWORDS];
    logic [DW-1:0] shadow [NWORDS];
    int rd_age = 0, oe_hi_age = 100;
    logic rd_cond, ram_drv;
    logic [DW-1:0] ram_q;

    assign rd_cond   = !mem_cs_n && !mem_oe_n && mem_we_n;
    assign ram_drv   = rd_cond || (oe_hi_age < RAM_REL);
    assign ram_q     = (rd_age >= TRD - 1) ? ram[mem_addr] : ~ram[mem_addr];
    assign mem_dq_in = ram_drv ? ram_q : (mem_dq_oe ? mem_dq_out : '0);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        rd_age <= rd_cond ? rd_age + 1 : 0;
        oe_hi_age <= mem_oe_n ? ((oe_hi_age < 100) ? oe_hi_age + 1 : 100) : 0;
    end

    // ---------------- pin monitor (negedge) ----------------
    int contention = 0, stray_done = 0;
    bit prev_we_low = 0, prev_oe_low = 0, cur_write = 0;
    int cs_low_len = 0, oe_low_len = 0, w_len = 0, w_setup = 0;
    logic [AW-1:0] w_addr;
    logic [DW-1:0] w_data;
    bit w_ok;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_dq_oe && ram_drv) contention++;
            if (rd_done && cur_write) stray_done++;
            if (!mem_we_n) begin
                if (!prev_we_low) begin
                    w_len = 0; w_addr = mem_addr; w_data = mem_dq_out;
                    w_ok = 1; w_setup = cs_low_len;
                end
                w_len++;
                if (!mem_dq_oe || mem_addr != w_addr || mem_dq_out != w_data || mem_cs_n)
                    w_ok = 0;
            end else if (prev_we_low) begin
                // R5 pulse width, setup, stable drive; R6 joint rise
                chk(w_ok && w_len == TWP && w_setup >= TWS && !mem_dq_oe, "R5 write pulse",
                    w_len, TWP);
                chk(mem_cs_n, "R6 cs rises with we", int'(mem_cs_n), 1);
                ram[w_addr] = w_data;
            end
            if (prev_oe_low && mem_oe_n) begin
                chk(oe_low_len == TRD && rd_done && mem_cs_n, "R2 read window", oe_low_len, TRD);
            end
            oe_low_len  = !mem_oe_n ? oe_low_len + 1 : 0;
            cs_low_len  = !mem_cs_n ? cs_low_len + 1 : 0;
            prev_we_low = !mem_we_n;
            prev_oe_low = !mem_oe_n;
        end
    end

    // ---------------- request driver ----------------
    int  last_acc = -1, prev_dur = 0;
    bit  prev_kind_rd = 0;

    task automatic do_op(input bit w, input int a, input logic [DW-1:0] d);
        int acc, dur;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = AW'(a); req_wdata = d;
        forever begin
            @(posedge clk);
            if (req_ready) break;
        end
        @(negedge clk);
        acc = cyc;
        req_valid = 1'b0;
        cur_write = w;
        if (last_acc >= 0)
            chk(acc - last_acc == prev_dur, "R9 request spacing", acc - last_acc, prev_dur);
        if (w) begin
            dur = ((last_acc >= 0 && prev_kind_rd) ? ((TWS > TTURN - TREC) ? TWS : TTURN - TREC) : TWS)
                  + TWP + TREC + 1;
            shadow[a] = d;
        end else begin
            dur = TRD + TREC + 1;
            while (!rd_done) @(negedge clk);
            chk(rd_data == shadow[a], "R2 read data", int'(rd_data), int'(shadow[a]));
        end
        last_acc = acc; prev_dur = dur; prev_kind_rd = !w;
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int p);
        return DW'(a * 29 + p * 83 + 5);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state during reset
        chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes in reset", int'({mem_cs_n, mem_we_n, mem_oe_n}), 7);
        chk(!mem_dq_oe, "R1 drive off in reset", int'(mem_dq_oe), 0);
        chk(req_ready && !rd_done, "R1 ready/done in reset", int'({req_ready, rd_done}), 2);
        rst_n = 1'b1;
        // R7 idle with no request: nothing moves
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready, "R7 idle ignored",
                int'({mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}), 14);
        end
        chk(!rd_done, "R1 done low after reset", int'(rd_done), 0);
        // sweep A: fill ascending, read back ascending
        for (int a = 0; a < NWORDS; a++) do_op(1'b1, a, pat(a, 0));
        for (int a = 0; a < NWORDS; a++) do_op(1'b0, a, '0);
        // sweep B: descending write-then-read pairs (write after read turnaround)
        for (int a = NWORDS - 1; a >= 0; a--) begin
            do_op(1'b1, a, pat(a, 1));
            do_op(1'b0, a, '0);
        end
        // sweep C: read everything again after the interleaved pass
        for (int a = 0; a < NWORDS; a++) do_op(1'b0, a, '0);
        repeat (8) @(negedge clk);
        chk(contention == 0, "R4 no bus contention", contention, 0);
        chk(stray_done == 0, "R10 no done on write", stray_done, 0);
        chk(mem_cs_n && req_ready, "R7 back to idle", int'({mem_cs_n, req_ready}), 3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule